// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is a single up-counting timer channel with a waveform output. A clock selector picks the event that advances the counter: one of four divided versions of the system clock, a rising edge of a slow reference clock, or a rising edge of an external clock pin. The two reference inputs are synchronised before use. Two compare values, A and C, are checked against the counter on every count step. Each match can set, clear or toggle the waveform pin. The C match can also reset the counter to zero (auto-reload) or switch the counter clock off (one-shot).

Software controls the channel through a small word-addressed register port. One command write can enable the counter clock, disable it, or trigger a restart from zero. Three event sources, overflow, A match and C match, are latched as status flags. The interrupt line is asserted while any latched flag is also enabled in the interrupt mask.

Top module: `tc_channel`

## Requirements
- R1: After reset the count, the clock status, the waveform output, the mode, both compare values, the interrupt mask and all status flags are zero, and the interrupt line is low.
- R2: The mode field sel (mode bits [2:0]) selects when the counter steps. Codes 0, 1, 2 and 3 step once every 2, 8, 32 and 128 system clocks; all four take their ticks from one shared free-running prescaler. Code 4 steps on each rising edge of the slow reference and code 5 on each rising edge of the external clock, each seen SYNC_STAGES+1 clocks after the input edge. Codes 6 and 7 never step.
- R3: Without auto-reload (mode bit 3 clear) the counter goes from all ones to zero on a step and sets the overflow flag (status bit 0).
- R4: With auto-reload (mode bit 3 set), a step taken while the count equals compare C loads zero, so the count never goes past C. A wrap caused this way does not set the overflow flag.
- R5: With stop-on-C (mode bit 4 set), a step taken while the count equals compare C still updates the count and then turns the clock status off.
- R6: In a write to the command word, bit 0 enables the clock, bit 1 disables it and bit 2 resets the count to zero. Disable wins over enable. A clock cycle that carries a command write never steps the counter, and the count holds whenever the clock status is off.
- R7: The compare actions ra_act (mode bits [6:5]) and rc_act (mode bits [8:7]) are coded 0 none, 1 set, 2 clear, 3 toggle. Each is applied to the waveform output on a step at which the count equals the matching compare value. When both compares match on the same step, only rc_act is applied. The output changes one clock after the step.
- R8: The status word (address 5) holds the flags overflow (bit 0), A match (bit 1) and C match (bit 2), plus the live clock status (bit 8). A read of the status word clears the three flags, but an event in the same cycle still sets its flag.
- R9: A write to address 6 sets the mask bits written as one. A write to address 7 clears the mask bits written as one, so writing 0xFF masks every source. The mask reads back at address 8. The interrupt line equals the OR of the flags ANDed with the mask.
- R10: The word addresses are: 0 command (write), 1 mode, 2 count (read only), 3 compare A, 4 compare C, 5 status, 6 mask set, 7 mask clear, 8 mask (read). Reads of write-only or unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | Slow reference clock, sampled through a synchroniser |
| ext_clk_i | input | 1 | External count clock, sampled through a synchroniser |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (used for the clear-on-read of the status word) |
| addr_i | input | 4 | Register word address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| tioa_o | output | 1 | Compare-driven waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W = 12 and SYNC_STAGES = 2. The narrower counter puts a full wrap through all ones only about 8k clocks away at divide-by-2. That makes the overflow flag and a full set-at-0 / clear-at-half square-wave period reachable within a short run. The status word's clock bit at position 8 still fits inside the narrower data word. The slow and external inputs toggle continuously at unrelated periods, so codes 4 and 5 are exercised through the synchroniser delay alongside the prescaler taps.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned NUM_DIV   = 4;
  localparam int unsigned LOG_FIRST = 1;
  localparam int unsigned LOG_STEP  = 2;
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned SRC_OVF   = 0;
  localparam int unsigned SRC_RA    = 1;
  localparam int unsigned SRC_RC    = 2;
  localparam int unsigned STAT_CLK_BIT = 8;

  localparam logic [ADDR_W-1:0] ADDR_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMPC  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_IDIS  = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_IMASK = 4'd8;

  typedef enum logic [2:0] {
    SEL_DIV2, SEL_DIV8, SEL_DIV32, SEL_DIV128,
    SEL_SLOW, SEL_EXT, SEL_OFF6, SEL_OFF7
  } clk_sel_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TGL} pin_act_e;

  typedef struct packed {
    pin_act_e rc_act;
    pin_act_e ra_act;
    logic     stop_rc;
    logic     auto_rst;
    clk_sel_e sel;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale
  import tc_pkg::*;
#(
  parameter int unsigned N_TAP = NUM_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [N_TAP-1:0] tick_o
);
  localparam int unsigned PRE_W = LOG_FIRST + LOG_STEP * (N_TAP - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // tap i fires once per 2**(LOG_FIRST+LOG_STEP*i) cycles
  for (genvar i = 0; i < N_TAP; i++) begin : g_tap
    localparam int unsigned LB = LOG_FIRST + LOG_STEP * i;
    assign tick_o[i] = &pre_q[LB-1:0];
  end
endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("rise pulse longer than one cycle"); // R2
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  mode_t              mode_i,
  input  logic [CNT_W-1:0]   ra_i,
  input  logic [CNT_W-1:0]   rc_i,
  input  logic               cmd_we_i,
  input  logic               cmd_en_i,
  input  logic               cmd_dis_i,
  input  logic               cmd_trig_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               clk_on_o,
  output logic               tioa_o,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;
  logic             pin_q, pin_d;
  logic             step, ra_hit, rc_hit, top_hit, reload;

  function automatic logic apply_act(pin_act_e act, logic cur);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  assign step    = on_q & tick_i & ~cmd_we_i;
  assign ra_hit  = (cnt_q == ra_i);
  assign rc_hit  = (cnt_q == rc_i);
  assign top_hit = &cnt_q;
  assign reload  = mode_i.auto_rst & rc_hit;

  always_comb begin
    evt_o          = '0;
    evt_o[SRC_OVF] = step & top_hit & ~reload;
    evt_o[SRC_RA]  = step & ra_hit;
    evt_o[SRC_RC]  = step & rc_hit;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_we_i && cmd_trig_i) cnt_d = '0;
    else if (step)              cnt_d = reload ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    on_d = on_q;
    if (cmd_we_i) begin
      if (cmd_dis_i)     on_d = 1'b0;
      else if (cmd_en_i) on_d = 1'b1;
    end else if (step && mode_i.stop_rc && rc_hit) begin
      on_d = 1'b0;
    end
  end

  always_comb begin
    pin_d = pin_q;
    if (step) begin
      if (rc_hit)      pin_d = apply_act(mode_i.rc_act, pin_q);
      else if (ra_hit) pin_d = apply_act(mode_i.ra_act, pin_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
      pin_q <= pin_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign clk_on_o = on_q;
  assign tioa_o   = pin_q;

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !reload) |=> ((cnt_q - $past(cnt_q)) == CNT_W'(1))) else $error("step not +1"); // R3
  AST_RELOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && reload) |=> (cnt_q == '0)) else $error("reload not zero"); // R4
  AST_ONESHOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i.stop_rc && rc_hit) |=> !clk_on_o) else $error("one-shot kept running"); // R5
  AST_TRIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_trig_i) |=> (cnt_o == '0)) else $error("trigger not zero"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(on_q && tick_i) && !(cmd_we_i && cmd_trig_i)) |=> $stable(cnt_o)) else $error("count moved"); // R6
  AST_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_dis_i) |=> !clk_on_o) else $error("disable lost"); // R6
endmodule

// File: rtl/tc_irq_ctrl.sv
module tc_irq_ctrl
  import tc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               stat_rd_i,
  input  logic               ien_we_i,
  input  logic               idis_we_i,
  input  logic [NUM_SRC-1:0] wbits_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] flags_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (stat_rd_i ? '0 : flags_q) | evt_i;
      if (ien_we_i)       mask_q <= mask_q | wbits_i;
      else if (idis_we_i) mask_q <= mask_q & ~wbits_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  AST_RDCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && evt_i == '0) |=> (flags_o == '0)) else $error("flags survived read"); // R8
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i))) else $error("event lost"); // R8
  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idis_we_i && !ien_we_i && (&wbits_i)) |=> (mask_o == '0 && !irq_o)) else $error("mask-all failed"); // R9
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              ext_clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              tioa_o,
  output logic              irq_o
);
  mode_t              mode_q;
  logic [CNT_W-1:0]   ra_q, rc_q, cnt;
  logic [NUM_DIV-1:0] div_tick;
  logic               slow_rise, ext_rise, tick, clk_on;
  logic [NUM_SRC-1:0] evt, flags, mask;
  logic               cmd_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ra_q   <= '0;
      rc_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_MODE: mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
        ADDR_CMPA: ra_q   <= wdata_i;
        ADDR_CMPC: rc_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  tc_prescale #(.N_TAP(NUM_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(div_tick)
  );

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(slow_clk_i), .rise_o(slow_rise)
  );

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i), .rise_o(ext_rise)
  );

  always_comb begin
    case (mode_q.sel)
      SEL_SLOW:           tick = slow_rise;
      SEL_EXT:            tick = ext_rise;
      SEL_OFF6, SEL_OFF7: tick = 1'b0;
      default:            tick = div_tick[mode_q.sel[1:0]];
    endcase
  end

  assign cmd_we = we_i && (addr_i == ADDR_CMD);

  tc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode_q),
    .ra_i      (ra_q),
    .rc_i      (rc_q),
    .cmd_we_i  (cmd_we),
    .cmd_en_i  (wdata_i[0]),
    .cmd_dis_i (wdata_i[1]),
    .cmd_trig_i(wdata_i[2]),
    .cnt_o     (cnt),
    .clk_on_o  (clk_on),
    .tioa_o    (tioa_o),
    .evt_o     (evt)
  );

  tc_irq_ctrl u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .stat_rd_i(re_i && (addr_i == ADDR_STAT)),
    .ien_we_i (we_i && (addr_i == ADDR_IEN)),
    .idis_we_i(we_i && (addr_i == ADDR_IDIS)),
    .wbits_i  (wdata_i[NUM_SRC-1:0]),
    .flags_o  (flags),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE:  rdata_o[MODE_W-1:0] = mode_q;
      ADDR_COUNT: rdata_o = cnt;
      ADDR_CMPA:  rdata_o = ra_q;
      ADDR_CMPC:  rdata_o = rc_q;
      ADDR_STAT: begin
        rdata_o[NUM_SRC-1:0]  = flags;
        rdata_o[STAT_CLK_BIT] = clk_on;
      end
      ADDR_IMASK: rdata_o[NUM_SRC-1:0] = mask;
      default: ;
    endcase
  end

  AST_CNT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_on && !(cmd_we && wdata_i[2])) |=> $stable(cnt)) else $error("count moved while off"); // R6
  AST_OFF_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.sel inside {SEL_OFF6, SEL_OFF7} && !(cmd_we && wdata_i[2])) |=> $stable(cnt)) else $error("off select stepped"); // R2
endmodule

// File: tb/tb_tc_channel.sv
module tb_tc_channel;
  localparam int CNT_W = 12;
  localparam int SYNC  = 2;

  logic clk_i = 1'b0, rst_n = 1'b0;
  logic slow = 1'b0, ext = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic tioa, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tc_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk_i), .rst_ni(rst_n), .slow_clk_i(slow), .ext_clk_i(ext),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tioa_o(tioa), .irq_o(irq)
  );

  // reference model state
  int m_pre, m_cnt, m_ra, m_rc, m_mode, m_flags, m_mask;
  bit m_on, m_pin;
  bit [SYNC-1:0] m_ss, m_se;
  bit m_ps, m_pe;
  localparam int CMAX = (1 << CNT_W) - 1;

  function automatic bit act(int a, bit cur);
    case (a)
      1: return 1'b1;
      2: return 1'b0;
      3: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ra = 0; m_rc = 0; m_mode = 0;
      m_flags = 0; m_mask = 0; m_on = 0; m_pin = 0;
      m_ss = '0; m_se = '0; m_ps = 0; m_pe = 0;
    end else begin
      int sel, au, st, raa, rca, ev, w;
      bit tk, cmdw, stp, rah, rch, rl;
      sel = m_mode & 7; au = (m_mode >> 3) & 1; st = (m_mode >> 4) & 1;
      raa = (m_mode >> 5) & 3; rca = (m_mode >> 7) & 3;
      w = int'(wdata);
      if (sel < 4) tk = ((m_pre % (2 ** (1 + 2*sel))) == (2 ** (1 + 2*sel)) - 1);
      else if (sel == 4) tk = m_ss[SYNC-1] && !m_ps;
      else if (sel == 5) tk = m_se[SYNC-1] && !m_pe;
      else tk = 0;
      cmdw = we && addr == 0;
      stp = m_on && tk && !cmdw;
      rah = (m_cnt == m_ra); rch = (m_cnt == m_rc); rl = au && rch;
      ev = 0;
      if (stp && m_cnt == CMAX && !rl) ev |= 1;
      if (stp && rah) ev |= 2;
      if (stp && rch) ev |= 4;
      if (stp) begin
        if (rch) m_pin = act(rca, m_pin);
        else if (rah) m_pin = act(raa, m_pin);
      end
      if (cmdw) begin
        if (w & 2) m_on = 0; else if (w & 1) m_on = 1;
        if (w & 4) m_cnt = 0;
      end else if (stp) begin
        if (st && rch) m_on = 0;
        m_cnt = rl ? 0 : (m_cnt + 1) & CMAX;
      end
      m_flags = ((re && addr == 5) ? 0 : m_flags) | ev;
      if (we && addr == 6) m_mask |= (w & 7);
      else if (we && addr == 7) m_mask &= ~(w & 7) & 7;
      if (we && addr == 1) m_mode = w & 9'h1FF;
      if (we && addr == 3) m_ra = w;
      if (we && addr == 4) m_rc = w;
      m_ps = m_ss[SYNC-1]; m_ss = {m_ss[SYNC-2:0], slow};
      m_pe = m_se[SYNC-1]; m_se = {m_se[SYNC-2:0], ext};
      m_pre = (m_pre + 1) % 128;
    end
  end

  function automatic int model_read(logic [3:0] a);
    case (a)
      1: return m_mode;
      2: return m_cnt;
      3: return m_ra;
      4: return m_rc;
      5: return (int'(m_on) << 8) | m_flags;
      8: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int actual, int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // per-cycle comparison of the pins
  always @(negedge clk_i) begin
    if (rst_n && !done) begin
      check(tioa == m_pin, "R7 tioa", int'(tioa), int'(m_pin));
      check(irq == |(m_flags & m_mask), "R9 irq", int'(irq), int'(|(m_flags & m_mask)));
    end
  end

  initial forever begin repeat (7) @(negedge clk_i); slow = ~slow; end
  initial forever begin repeat (3) @(negedge clk_i); ext = ~ext; end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk_i); we = 1; addr = a; wdata = CNT_W'(d);
    @(negedge clk_i); we = 0; addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, output int v);
    int e;
    @(negedge clk_i); re = 1; addr = a; #1;
    v = int'(rdata); e = model_read(a);
    check(v == e, tag, v, e);
    @(negedge clk_i); re = 0; addr = '0;
  endtask

  function automatic int mk_mode(int sel, int au, int st, int raa, int rca);
    return (rca << 7) | (raa << 5) | (st << 4) | (au << 3) | sel;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk_i);
    rst_n = 1;
    // R1 reset state
    rd(4'd2, "R1 count", v); check(v == 0, "R1 count literal", v, 0);
    rd(4'd5, "R1 status", v); check(v == 0, "R1 status literal", v, 0);
    rd(4'd8, "R1 mask", v); check(v == 0, "R1 mask literal", v, 0);
    rd(4'd1, "R1 mode", v); check(v == 0, "R1 mode literal", v, 0);
    check(tioa == 0 && irq == 0, "R1 pins", int'({tioa, irq}), 0);

    // R6 enable+trigger, R8 clock status bit
    wr(4'd1, mk_mode(1, 0, 0, 0, 0));
    wr(4'd0, 5);
    repeat (80) @(negedge clk_i);
    rd(4'd2, "R6 count running", v);
    check(v > 0, "R6 counting after start", v, 1);
    rd(4'd5, "R8 status on", v);
    check((v & 256) != 0, "R8 clock bit on", v, 256);
    // R6 disable wins over enable
    wr(4'd0, 3);
    rd(4'd5, "R6 status off", v);
    check((v & 256) == 0, "R6 disable wins", v, 0);
    rd(4'd2, "R6 hold a", v);
    begin
      int v2;
      repeat (20) @(negedge clk_i);
      rd(4'd2, "R6 hold b", v2);
      check(v2 == v, "R6 count frozen", v2, v);
    end
    // R6 trigger alone resets but leaves clock off
    wr(4'd0, 4);
    rd(4'd2, "R6 trig count", v); check(v == 0, "R6 trig zero", v, 0);
    rd(4'd5, "R6 trig clk", v); check((v & 256) == 0, "R6 trig keeps off", v, 0);

    // R2 every clock select
    for (int s = 0; s < 8; s++) begin
      wr(4'd1, mk_mode(s, 0, 0, 0, 0));
      wr(4'd0, 5);
      repeat (290) @(negedge clk_i);
      rd(4'd2, "R2 select count", v);
      if (s >= 6) check(v == 0, "R2 off select", v, 0);
      else check(v > 0, "R2 select steps", v, 1);
    end

    // R4 auto-reload, R7 RA set / RC clear
    wr(4'd0, 2);
    wr(4'd3, 2); wr(4'd4, 5);
    wr(4'd1, mk_mode(0, 1, 0, 1, 2));
    wr(4'd0, 5);
    for (int k = 0; k < 20; k++) begin
      rd(4'd2, "R4 reload count", v);
      check(v <= 5, "R4 never past C", v, 5);
      repeat (k % 3) @(negedge clk_i);
    end

    // R5 one-shot
    wr(4'd0, 2);
    rd(4'd5, "R8 clear before", v);
    rd(4'd5, "R8 cleared", v); check((v & 7) == 0, "R8 read clears", v, 0);
    wr(4'd3, 3); wr(4'd4, 10);
    wr(4'd1, mk_mode(0, 1, 1, 0, 0));
    wr(4'd0, 5);
    repeat (60) @(negedge clk_i);
    rd(4'd2, "R5 count", v); check(v == 0, "R5 reloaded zero", v, 0);
    rd(4'd5, "R5 status", v); check(v == 6, "R5 stopped with A,C flags", v, 6);
    repeat (10) @(negedge clk_i);
    rd(4'd2, "R5 stays", v); check(v == 0, "R5 stays stopped", v, 0);

    // R9 mask set / clear
    wr(4'd6, 7);
    rd(4'd8, "R9 mask all", v); check(v == 7, "R9 mask set", v, 7);
    wr(4'd7, 8'hFF);
    rd(4'd8, "R9 mask none", v); check(v == 0, "R9 mask cleared", v, 0);
    wr(4'd6, 1);
    rd(4'd8, "R9 mask ovf", v); check(v == 1, "R9 mask ovf only", v, 1);

    // R3 wrap and overflow, R7 square wave
    wr(4'd0, 2);
    rd(4'd5, "R8 clear pre-wrap", v);
    wr(4'd3, 0); wr(4'd4, 1 << (CNT_W - 1));
    wr(4'd1, mk_mode(0, 0, 0, 1, 2));
    wr(4'd0, 5);
    repeat (8300) @(negedge clk_i);
    check(irq == 1, "R3 overflow irq", int'(irq), 1);
    rd(4'd5, "R3 status", v); check(v == 263, "R3 overflow flag", v, 263);
    check(irq == 0, "R8 read cleared irq", int'(irq), 0);

    // R7 both compares match: RC action wins
    wr(4'd3, 3); wr(4'd4, 3);
    wr(4'd1, mk_mode(0, 1, 0, 1, 2));
    wr(4'd0, 5);
    repeat (40) @(negedge clk_i);
    check(tioa == 0, "R7 rc wins", int'(tioa), 0);
    // R7 toggle
    wr(4'd1, mk_mode(0, 1, 0, 0, 3));
    wr(4'd0, 5);
    repeat (60) @(negedge clk_i);

    // R10 unused / write-only reads
    rd(4'd0, "R10 cmd reads zero", v); check(v == 0, "R10 cmd zero", v, 0);
    rd(4'd15, "R10 unused zero", v); check(v == 0, "R10 unused", v, 0);
    rd(4'd4, "R10 cmpc readback", v); check(v == 3, "R10 cmpc value", v, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule